// File: doc/BRIEF.md
# Serial Variable-Length Opcode Decoder

This block turns a serial stream of opcodes, one bit per clock, into fixed-width opcode indices. The opcodes use a prefix-free code of unequal lengths, so the stream holds no separators and no length fields. The decoder finds where each opcode ends from the code alone. It starts at the root of a binary code tree and moves down one level for each accepted bit. When it reaches a leaf, it reports that leaf's index and returns to the root.

The decoder sits behind a serializer that offers a bit together with a valid qualifier. Cycles without a valid bit may fall anywhere, including inside a codeword. A flush input drops a partly received codeword so that decoding can start again on a known boundary.

Top module: `serial_opcode_walker`

## Requirements
- R1: After a synchronous reset, op_done_o is 0, op_idx_o is 0 and the walk is at the root.
- R2: The code set and its indices are: 00 gives index 0, 01 gives index 1, 10 gives index 2, 110 gives index 3 and 111 gives index 4. The first bit received is the most significant bit of the codeword.
- R3: op_done_o is high for exactly one cycle. That cycle is the one after the clock edge that accepts the last bit of a codeword, and op_idx_o shows the decoded index in the same cycle.
- R4: Codewords may follow one another with no gap. A valid bit offered while op_done_o is high is the first bit of the next codeword.
- R5: A cycle with bit_valid_i low does not move the tree position, and op_done_o is low in the cycle after it.
- R6: When flush_i is high, the walk returns to the root and op_done_o is low in the next cycle. A bit offered together with flush_i is discarded.
- R7: op_idx_o keeps the last decoded index until the next codeword completes.
- R8: A reset in the middle of a codeword discards the bits received so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Drops the partial codeword and returns the walk to the root |
| bit_valid_i | input | 1 | Qualifies bit_i |
| bit_i | input | 1 | Serial code bit, most significant bit first |
| op_done_o | output | 1 | One-cycle strobe: a codeword has completed |
| op_idx_o | output | 3 | Index of the last completed codeword |

## Verification
A wrong tree position does not show at once. It shows when the next codeword completes, and at the latest within three accepted bits. It can appear as a wrong index, as a strobe that arrives one bit early or late, or as all later boundaries shifted. For this reason the bench checks the strobe after every bit, not only at the expected leaves. It runs back-to-back streams so that a single lost or extra bit shifts every index that follows. Gaps, flushes and a reset are placed in the middle of codewords, where a position that was not kept or not cleared would change the result.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam int unsigned OP_COUNT = 5;
  localparam int unsigned CODE_MAX = 3;

  // Codeword length for each index.
  function automatic int unsigned code_len(input int unsigned i);
    case (i)
      0, 1, 2: code_len = 2;
      default: code_len = 3;
    endcase
  endfunction

  // Codeword bits, right aligned, first received bit is the MSB.
  function automatic logic [15:0] code_bits(input int unsigned i);
    case (i)
      0:       code_bits = 16'b00;
      1:       code_bits = 16'b01;
      2:       code_bits = 16'b10;
      3:       code_bits = 16'b110;
      default: code_bits = 16'b111;
    endcase
  endfunction
endpackage

// File: rtl/sdec_path_reg.sv
module sdec_path_reg #(
  parameter int unsigned MAX_BITS = sdec_pkg::CODE_MAX,
  localparam int unsigned DEPTH_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                flush_i,
  input  logic                valid_i,
  input  logic                bit_i,
  input  logic                leaf_hit_i,
  output logic [MAX_BITS-1:0] cand_prefix_o,
  output logic [DEPTH_W-1:0]  cand_len_o
);
  logic [MAX_BITS-2:0] prefix_q;
  logic [DEPTH_W-1:0]  depth_q;

  assign cand_prefix_o = {prefix_q, bit_i};
  assign cand_len_o    = depth_q + DEPTH_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      prefix_q <= '0;
      depth_q  <= '0;
    end else if (valid_i) begin
      if (leaf_hit_i || cand_len_o == DEPTH_W'(MAX_BITS)) begin
        prefix_q <= '0;
        depth_q  <= '0;
      end else begin
        prefix_q <= cand_prefix_o[MAX_BITS-2:0];
        depth_q  <= cand_len_o;
      end
    end
  end

  // R5: an idle cycle keeps the tree position
  a_r5_hold_position: assert property (@(posedge clk_i) disable iff (rst_i)
    (!valid_i && !flush_i) |=> ($stable(depth_q) && $stable(prefix_q)));
  // R6: a flush lands at the root
  a_r6_flush_root: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> (depth_q == '0 && prefix_q == '0));
  // R2: the walk never sits at or below the deepest leaf level
  a_r2_depth_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    depth_q < DEPTH_W'(MAX_BITS));
endmodule

// File: rtl/sdec_leaf_match.sv
module sdec_leaf_match #(
  parameter int unsigned NUM_OPS  = sdec_pkg::OP_COUNT,
  parameter int unsigned MAX_BITS = sdec_pkg::CODE_MAX,
  localparam int unsigned DEPTH_W = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W   = $clog2(NUM_OPS)
) (
  input  logic [MAX_BITS-1:0] cand_prefix_i,
  input  logic [DEPTH_W-1:0]  cand_len_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [NUM_OPS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_leaf
    localparam logic [15:0] WANT = sdec_pkg::code_bits(g);
    localparam logic [DEPTH_W-1:0] LEN = DEPTH_W'(sdec_pkg::code_len(g));
    assign hit_vec[g] = (cand_len_i == LEN) && (cand_prefix_i == WANT[MAX_BITS-1:0]);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
    hit_o = |hit_vec;
    // R2: a prefix-free set gives at most one leaf per step
    a_r2_prefix_free: assert ($onehot0(hit_vec));
  end
endmodule

// File: rtl/sdec_out_reg.sv
module sdec_out_reg #(
  parameter int unsigned NUM_OPS = sdec_pkg::OP_COUNT,
  localparam int unsigned IDX_W  = $clog2(NUM_OPS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             flush_i,
  input  logic             valid_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      done_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      done_o <= valid_i && hit_i && !flush_i;
      if (valid_i && hit_i && !flush_i) idx_o <= idx_i;
    end
  end

  // R3: shortest codeword is two bits, so the strobe never repeats
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
  // R5: no completion without an accepted bit
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |=> !done_o);
  // R6: flush suppresses the strobe
  a_r6_flush_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> !done_o);
  // R7: index is held between completions
  a_r7_idx_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_i && hit_i) |=> $stable(idx_o));
  // R2: reported index is in range
  a_r2_idx_range: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (idx_o < IDX_W'(NUM_OPS)));
endmodule

// File: rtl/serial_opcode_walker.sv
module serial_opcode_walker #(
  parameter int unsigned NUM_OPS  = sdec_pkg::OP_COUNT,
  parameter int unsigned MAX_BITS = sdec_pkg::CODE_MAX,
  localparam int unsigned DEPTH_W = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W   = $clog2(NUM_OPS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             flush_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             op_done_o,
  output logic [IDX_W-1:0] op_idx_o
);
  logic [MAX_BITS-1:0] cand_prefix;
  logic [DEPTH_W-1:0]  cand_len;
  logic                leaf_hit;
  logic [IDX_W-1:0]    leaf_idx;

  sdec_path_reg #(.MAX_BITS(MAX_BITS)) path_i (
    .clk_i(clk_i), .rst_i(rst_i), .flush_i(flush_i), .valid_i(bit_valid_i),
    .bit_i(bit_i), .leaf_hit_i(leaf_hit),
    .cand_prefix_o(cand_prefix), .cand_len_o(cand_len)
  );

  sdec_leaf_match #(.NUM_OPS(NUM_OPS), .MAX_BITS(MAX_BITS)) match_i (
    .cand_prefix_i(cand_prefix), .cand_len_i(cand_len),
    .hit_o(leaf_hit), .idx_o(leaf_idx)
  );

  sdec_out_reg #(.NUM_OPS(NUM_OPS)) out_i (
    .clk_i(clk_i), .rst_i(rst_i), .flush_i(flush_i), .valid_i(bit_valid_i),
    .hit_i(leaf_hit), .idx_i(leaf_idx), .done_o(op_done_o), .idx_o(op_idx_o)
  );
endmodule

// File: tb/serial_opcode_walker_tb.sv
`timescale 1ns/1ps
module serial_opcode_walker_tb_top;
  logic clk = 1'b0;
  logic rst, flush, vld, b;
  logic done;
  logic [2:0] idx;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_opcode_walker dut_i (
    .clk_i(clk), .rst_i(rst), .flush_i(flush), .bit_valid_i(vld),
    .bit_i(b), .op_done_o(done), .op_idx_o(idx)
  );

  function automatic int code_of(input int i);
    case (i) 0: return 0; 1: return 1; 2: return 2; 3: return 6; default: return 7; endcase
  endfunction
  function automatic int len_of(input int i);
    return (i < 3) ? 2 : 3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; offers one bit, returns at the next negedge.
  task automatic push(input logic v);
    vld = 1'b1; b = v;
    @(posedge clk); @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send_code(input string req, input int i);
    for (int k = len_of(i) - 1; k >= 0; k--) begin
      push(code_of(i)[k]);
      if (k != 0) check({req, " mid-code strobe"}, done, 0);
    end
    check({req, " strobe"}, done, 1);
    check({req, " index"}, idx, i);
  endtask

  task automatic t_reset();
    rst = 1'b1; flush = 1'b0; vld = 1'b0; b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 done after reset", done, 0);
    check("R1 idx after reset", idx, 0);
    send_code("R1 root after reset", 2);
  endtask

  task automatic t_each_code();
    for (int i = 0; i < 5; i++) begin
      send_code("R2", i);
      idle();
      check("R3 strobe one cycle", done, 0);
    end
  endtask

  task automatic t_stream();
    int seq[8] = '{3, 0, 4, 1, 2, 4, 3, 0};
    foreach (seq[n]) send_code("R4 back-to-back", seq[n]);
  endtask

  task automatic t_gaps();
    push(1'b1);
    for (int k = 0; k < 3; k++) begin idle(); check("R5 gap quiet", done, 0); end
    push(1'b1);
    idle(); check("R5 gap quiet", done, 0);
    push(1'b0);
    check("R5 strobe after gaps", done, 1);
    check("R5 index after gaps", idx, 3);
  endtask

  task automatic t_hold();
    send_code("R7 setup", 4);
    for (int k = 0; k < 4; k++) begin idle(); check("R7 idx hold", idx, 4); end
    push(1'b1);
    check("R7 idx hold mid-code", idx, 4);
    push(1'b0);
    check("R7 new index", idx, 2);
  endtask

  task automatic t_flush();
    push(1'b1); push(1'b1);
    flush = 1'b1; idle(); flush = 1'b0;
    check("R6 flush quiet", done, 0);
    send_code("R6 after flush", 0);
    push(1'b1);
    flush = 1'b1; vld = 1'b1; b = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0; vld = 1'b0;
    check("R6 flush with bit quiet", done, 0);
    send_code("R6 bit with flush dropped", 1);
  endtask

  task automatic t_reset_mid();
    push(1'b1);
    rst = 1'b1; idle(); rst = 1'b0;
    check("R8 done after mid reset", done, 0);
    check("R8 idx after mid reset", idx, 0);
    send_code("R8 root after mid reset", 1);
  endtask

  initial begin
    rst = 1'b1; flush = 1'b0; vld = 1'b0; b = 1'b0;
    @(negedge clk);
    t_reset();
    t_each_code();
    t_stream();
    t_gaps();
    t_hold();
    t_flush();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule